// File: doc/BRIEF.md
# I2C Bus Condition Generator

This block is the master-side part of an I2C controller that creates START and STOP conditions on the bus. Software controls it with a single write to an eight-bit status/mode register. Setting master, transmit and busy together in one write requests a START. Setting master and transmit while clearing busy requests a STOP.

The block drives two open-drain enables, one for SCL and one for SDA. A 1 on an enable pulls that line low, and a 0 releases it. All timing is counted in system clock cycles, and a speed-mode input selects the standard or the fast set of counts. After a START, the block clocks out one byte worth of SCL pulses. It then holds SCL low and raises an active-low interrupt request.

The busy flag moves on its own timer, which starts at the write and is separate from the line setup and hold timing. The low four register bits only mirror status inputs that other logic supplies.

Top module: `i2c_cond_gen`

## Requirements
- R1: A START is accepted only when `if_en` is 1, the write data has bits [7:5] = 3'b111, and the busy flag reads 0.
- R2: START waveform. After the accepting clock edge, both lines stay released for SETUP cycles. SDA is then pulled low while SCL stays released, for HOLD cycles. After that, SCL is pulled low. Counts are SETUP=HOLD=20 in standard mode (`fast_mode`=0).
- R3: A STOP is accepted only when `if_en` is 1, the write data has bits [7:5] = 3'b110, and the busy flag reads 1. SCL is released and SDA is held low for SETUP cycles. SDA is then released, and both lines stay released for HOLD cycles and afterwards.
- R4: The busy flag (`status[5]`) becomes 1 exactly BB_DLY cycles after an accepted START write. It becomes 0 exactly BB_DLY cycles after an accepted STOP write. BB_DLY is 12 in standard mode and 6 in fast mode.
- R5: In fast mode (`fast_mode`=1), SETUP=HOLD=10 and each SCL half-period is 10 cycles. In standard mode each SCL half-period is 20 cycles.
- R6: After a START, SCL gives 8 pulses, each a low half followed by a released half. `bit_cnt` is 0 at the START and increments at the end of each released half. It wraps to 0 after the eighth bit.
- R7: When the eighth bit ends, the block pulls SCL low and keeps it low until a STOP, and PIN (`status[4]`) drops to 0. Any accepted write sets PIN back to 1.
- R8: `status` is {MST, TRX, BB, PIN, AL, AAS, AD0, LRB}, from bit 7 down to bit 0. MST and TRX take `wr_data[7:6]` on every accepted write. Mode codes are 00 slave receive, 01 slave transmit, 10 master receive and 11 master transmit. Reset value is 8'b0001_0000 when all flag inputs are 0.
- R9: `status[3:0]` always equals {`al_in`, `aas_in`, `ad0_in`, `lrb_in`}. The values written to `wr_data[3:0]` have no effect.
- R10: Some writes are ignored: a write while `if_en` is 0, or any write while a condition or busy timer is running. An ignored write leaves the register and the lines unchanged. An accepted write that matches neither pattern changes only MST/TRX/PIN and produces no line activity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| if_en | input | 1 | Interface enable; writes ignored when 0 |
| fast_mode | input | 1 | 1 selects fast timing, 0 standard |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write data |
| al_in | input | 1 | Arbitration-lost flag from bus monitor |
| aas_in | input | 1 | Address-match flag from slave logic |
| ad0_in | input | 1 | General-call flag from slave logic |
| lrb_in | input | 1 | Last received bit |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |
| bit_cnt | output | 3 | Bit counter of the current byte |
| status | output | 8 | Register read value |

## Verification
The bench samples the lines in the last cycle before each edge and in the first cycle after it, in both speed modes. A design whose counters were off by one, or that used the wrong mode counts, would therefore miss a check. It also checks that the busy flag moves on its own delay, separate from the SDA edge, which would catch a design that tied busy to the SDA transition. Writes are also issued while disabled, with non-matching patterns, during a running START, as a second START on a busy bus and as a STOP on a free bus. A design that honoured any of these would toggle a line or change the mode bits. The bench also checks that SCL stays held low and PIN stays low after the byte, that an accepted write releases PIN, and that the low register bits ignore written data and follow their inputs.

// File: rtl/i2c_cond_gen.sv
module i2c_cond_gen #(
  parameter int STD_SETUP  = 20,
  parameter int STD_HOLD   = 20,
  parameter int STD_BB     = 12,
  parameter int STD_HALF   = 20,
  parameter int FAST_SETUP = 10,
  parameter int FAST_HOLD  = 10,
  parameter int FAST_BB    = 6,
  parameter int FAST_HALF  = 10
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       if_en,
  input  logic       fast_mode,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  input  logic       al_in,
  input  logic       aas_in,
  input  logic       ad0_in,
  input  logic       lrb_in,
  output logic       scl_oe,
  output logic       sda_oe,
  output logic [2:0] bit_cnt,
  output logic [7:0] status
);

  localparam int CW = $clog2(STD_SETUP + STD_HOLD + STD_BB + STD_HALF +
                             FAST_SETUP + FAST_HOLD + FAST_BB + FAST_HALF + 1);

  typedef enum logic [1:0] {ST_IDLE, ST_SETUP, ST_HOLD, ST_BYTE} st_t;

  st_t          st;
  logic         is_start, ph_high, hold_low, fast_q;
  logic         mst, trx, bb, pin, bb_pend, bb_tgt;
  logic [CW-1:0] cnt, bb_cnt;

  wire seq_busy = (st != ST_IDLE) || bb_pend;
  wire wr_ok    = wr_en && if_en && !seq_busy;
  wire go_start = wr_ok && (wr_data[7:5] == 3'b111) && !bb;
  wire go_stop  = wr_ok && (wr_data[7:5] == 3'b110) && bb;
  wire go       = go_start || go_stop;

  wire [CW-1:0] t_setup = fast_q ? CW'(FAST_SETUP) : CW'(STD_SETUP);
  wire [CW-1:0] t_hold  = fast_q ? CW'(FAST_HOLD)  : CW'(STD_HOLD);
  wire [CW-1:0] t_half  = fast_q ? CW'(FAST_HALF)  : CW'(STD_HALF);
  wire [CW-1:0] t_go_su = fast_mode ? CW'(FAST_SETUP) : CW'(STD_SETUP);
  wire [CW-1:0] t_go_bb = fast_mode ? CW'(FAST_BB)    : CW'(STD_BB);

  assign sda_oe = (st == ST_SETUP && !is_start) || (st == ST_HOLD && is_start);
  assign scl_oe = (st == ST_BYTE && !ph_high) || (st == ST_IDLE && hold_low);
  assign status = {mst, trx, bb, pin, al_in, aas_in, ad0_in, lrb_in};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      cnt      <= '0;
      is_start <= 1'b0;
      ph_high  <= 1'b0;
      hold_low <= 1'b0;
      fast_q   <= 1'b0;
      bit_cnt  <= 3'd0;
      mst      <= 1'b0;
      trx      <= 1'b0;
      pin      <= 1'b1;
    end else begin
      if (wr_ok) begin
        mst <= wr_data[7];
        trx <= wr_data[6];
        pin <= 1'b1;
      end
      case (st)
        ST_IDLE: if (go) begin
          st       <= ST_SETUP;
          cnt      <= t_go_su - CW'(1);
          is_start <= go_start;
          fast_q   <= fast_mode;
          if (go_start) bit_cnt <= 3'd0;
        end
        ST_SETUP: if (cnt == '0) begin
          st  <= ST_HOLD;
          cnt <= t_hold - CW'(1);
        end else cnt <= cnt - CW'(1);
        ST_HOLD: if (cnt == '0) begin
          if (is_start) begin
            st      <= ST_BYTE;
            cnt     <= t_half - CW'(1);
            ph_high <= 1'b0;
          end else begin
            st       <= ST_IDLE;
            hold_low <= 1'b0;
          end
        end else cnt <= cnt - CW'(1);
        ST_BYTE: if (cnt == '0) begin
          cnt <= t_half - CW'(1);
          if (!ph_high) ph_high <= 1'b1;
          else begin
            ph_high <= 1'b0;
            bit_cnt <= bit_cnt + 3'd1;
            if (bit_cnt == 3'd7) begin
              st       <= ST_IDLE;
              hold_low <= 1'b1;
              pin      <= 1'b0;
            end
          end
        end else cnt <= cnt - CW'(1);
        default: st <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bb      <= 1'b0;
      bb_pend <= 1'b0;
      bb_tgt  <= 1'b0;
      bb_cnt  <= '0;
    end else if (go) begin
      bb_pend <= 1'b1;
      bb_tgt  <= go_start;
      bb_cnt  <= t_go_bb;
    end else if (bb_pend) begin
      if (bb_cnt == CW'(1)) begin
        bb      <= bb_tgt;
        bb_pend <= 1'b0;
      end else bb_cnt <= bb_cnt - CW'(1);
    end
  end

  p_sda_low_scl_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_oe);

  p_bb_only_timer_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !bb_pend |=> $stable(bb));

  p_bb_set_start_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bb) |-> (st != ST_IDLE) && is_start);

  p_bb_clr_stop_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bb) |-> (st != ST_IDLE) && !is_start);

  p_pin_after_byte_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pin) |-> scl_oe && (bit_cnt == 3'd0));

  p_busy_write_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && st != ST_IDLE) |=> $stable(mst) && $stable(trx));

endmodule

// File: tb/test_i2c_cond_gen.sv
module test_i2c_cond_gen;
  localparam int PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0, if_en = 1'b0, fast_mode = 1'b0, wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic al_in = 1'b0, aas_in = 1'b0, ad0_in = 1'b0, lrb_in = 1'b0;
  logic scl_oe, sda_oe;
  logic [2:0] bit_cnt;
  logic [7:0] status;

  i2c_cond_gen i_i2c_cond_gen (
    .clk(clk), .rst_n(rst_n), .if_en(if_en), .fast_mode(fast_mode),
    .wr_en(wr_en), .wr_data(wr_data), .al_in(al_in), .aas_in(aas_in),
    .ad0_in(ad0_in), .lrb_in(lrb_in), .scl_oe(scl_oe), .sda_oe(sda_oe),
    .bit_cnt(bit_cnt), .status(status));

  typedef struct {
    int         at;
    logic [6:0] exp;
    string      tag;
  } item_t;

  item_t q[$];
  int cyc = 0, total = 0, bad = 0;
  bit done = 1'b0;

  always #(PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    while (q.size() > 0 && q[0].at <= cyc) begin
      item_t it;
      logic [6:0] act;
      it  = q.pop_front();
      act = {sda_oe, scl_oe, status[5], status[4], bit_cnt};
      total++;
      if (it.at != cyc || act != it.exp) begin
        bad++;
        $display("FAIL %s cyc=%0d act=%b exp=%b (sda,scl,bb,pin,bitcnt)", it.tag, cyc, act, it.exp);
      end
    end
  end

  task automatic push(int at, bit sda, bit scl, bit b, bit p, int bc, string tag);
    item_t it;
    it.at  = at;
    it.exp = {sda, scl, b, p, 3'(bc)};
    it.tag = tag;
    q.push_back(it);
  endtask

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%b exp=%b", tag, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_data = d;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic run_start(bit f);
    int w, s, h, b, hf, g;
    s = f ? 10 : 20; h = s; b = f ? 6 : 12; hf = f ? 10 : 20;
    @(negedge clk);
    wr_en = 1'b1; wr_data = 8'hE0;
    w = cyc + 1; g = w + s + h;
    push(w,            0, 0, 0, 1, 0, "R1 start accepted");
    push(w + b - 1,    0, 0, 0, 1, 0, "R4 bb before set");
    push(w + b,        0, 0, 1, 1, 0, "R4 bb set");
    push(w + s - 1,    0, 0, 1, 1, 0, "R2 setup end");
    push(w + s,        1, 0, 1, 1, 0, f ? "R5 sda low" : "R2 sda low");
    push(g - 1,        1, 0, 1, 1, 0, "R2 hold end");
    push(g,            0, 1, 1, 1, 0, f ? "R5 scl low" : "R2 scl low");
    push(g + hf,       0, 0, 1, 1, 0, "R6 first high half");
    push(g + 2*hf,     0, 1, 1, 1, 1, "R6 bit count one");
    push(g + 16*hf - 1,0, 0, 1, 1, 7, "R6 last high half");
    push(g + 16*hf,    0, 1, 1, 0, 0, "R7 pin low scl held");
    push(g + 16*hf + 3,0, 1, 1, 0, 0, "R7 scl still held");
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic run_stop(bit f);
    int w, s, h, b;
    s = f ? 10 : 20; h = s; b = f ? 6 : 12;
    @(negedge clk);
    wr_en = 1'b1; wr_data = 8'hC0;
    w = cyc + 1;
    push(w,             1, 0, 1, 1, 0, "R3 stop setup");
    push(w + b - 1,     1, 0, 1, 1, 0, "R4 bb before clear");
    push(w + b,         1, 0, 0, 1, 0, "R4 bb clear");
    push(w + s - 1,     1, 0, 0, 1, 0, "R3 setup end");
    push(w + s,         0, 0, 0, 1, 0, f ? "R5 sda release" : "R3 sda release");
    push(w + s + h - 1, 0, 0, 0, 1, 0, "R3 hold end");
    push(w + s + h + 5, 0, 0, 0, 1, 0, "R3 lines free");
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R8 reset status", status, 8'b0001_0000);
    chk("R8 reset lines", {3'b0, sda_oe, scl_oe, bit_cnt}, 8'h00);

    al_in = 1'b1; aas_in = 1'b0; ad0_in = 1'b1; lrb_in = 1'b1;
    if_en = 1'b1;
    wr(8'b0100_0100);
    chk("R9 low bits follow inputs", status, 8'b0101_1011);
    al_in = 1'b0; aas_in = 1'b1; ad0_in = 1'b1; lrb_in = 1'b0;
    @(negedge clk);
    chk("R9 low bits track", status, 8'b0101_0110);
    al_in = 1'b0; aas_in = 1'b0; ad0_in = 1'b0; lrb_in = 1'b0;

    if_en = 1'b0;
    wr(8'hE0);
    repeat (25) @(negedge clk);
    chk("R10 disabled write ignored", status, 8'b0101_0000);
    chk("R10 disabled no lines", {6'b0, sda_oe, scl_oe}, 8'h00);
    if_en = 1'b1;

    wr(8'hA0);
    repeat (25) @(negedge clk);
    chk("R10 nonmatching mode bits", status, 8'b1001_0000);
    chk("R10 nonmatching no lines", {6'b0, sda_oe, scl_oe}, 8'h00);

    wr(8'hC0);
    repeat (25) @(negedge clk);
    chk("R3 stop on free bus ignored", status, 8'b1101_0000);
    chk("R3 stop free no lines", {6'b0, sda_oe, scl_oe}, 8'h00);

    run_start(1'b0);
    repeat (4) @(negedge clk);
    wr(8'h00);
    @(negedge clk);
    chk("R10 write while busy ignored", {6'b0, status[7:6]}, 8'h03);
    wait (q.size() == 0);
    @(negedge clk);
    chk("R8 master transmit pin low", status, 8'b1110_0000);
    run_stop(1'b0);
    wait (q.size() == 0);

    fast_mode = 1'b1;
    run_start(1'b1);
    wait (q.size() == 0);
    wr(8'hE0);
    repeat (30) @(negedge clk);
    chk("R1 start on busy bus ignored", {3'b0, sda_oe, scl_oe, bit_cnt}, 8'b0000_1000);
    chk("R7 accepted write releases pin", status, 8'b1111_0000);
    run_stop(1'b1);
    wait (q.size() == 0);
    repeat (5) @(negedge clk);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule